// File: doc/BRIEF.md
# Paged Serial EEPROM Slave

This block is the two-wire (I2C/SMBus compatible) slave front end of a 256-byte nonvolatile store. The store is modelled as a register array that starts with every byte at 0xFF. The block oversamples the bus clock and data lines with the system clock, finds START and STOP conditions, and checks the address byte against a fixed memory-select code and three strap inputs. Its only bus output is an SDA pull-down enable, which it uses to acknowledge and to shift out read data.

A host writes by sending an address byte and then one or more data bytes. The data collects in a 16-entry page buffer and is written to the array only after STOP, during a timed write cycle. While that cycle runs, the slave answers no address, so the host can poll until the slave acknowledges again. Reads start at an internal byte pointer. A host that sends an address-only write followed by a repeated START can move that pointer first. A separate protection block can mark the lower half of the array as read-only. A bus clock held low for too long during a transfer returns the interface to idle.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_pd_o` = 0), the byte pointer is 0x00 and every array byte reads 0xFF.
- R2: The slave acknowledges an address byte only when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects the direction, with 1 meaning read. Any other address byte gets no acknowledge.
- R3: In a write, the slave acknowledges the address byte, the byte-address byte and every data byte.
- R4: In a write, the upper 4 bits of the byte address select the page and only the lower 4 bits advance after each data byte. A 17th or later byte overwrites an earlier byte of the same page, and other pages stay unchanged.
- R5: The array is updated only by a write cycle that starts at STOP and lasts `WR_CYCLES` clocks, using the last data loaded for each page position. An address-only write, or a write cut short by a repeated START, starts no cycle.
- R6: While a write cycle runs, the slave does not acknowledge its address and never pulls SDA low. Once the cycle ends it acknowledges again.
- R7: A read returns the byte at the pointer and then increments the pointer after each byte sent, wrapping from 0xFF to 0x00. The next immediate read continues from that pointer.
- R8: An address-only write followed by a repeated START and a read returns data starting at the byte address just sent.
- R9: When the master does not acknowledge a read byte, the slave stops sending and leaves SDA released through the following STOP.
- R10: Data is sampled on the rising SCL edge. The slave starts pulling SDA low only while SCL is low and never changes `sda_pd_o` while SCL is high.
- R11: While `wp_lo_i` is 1, data bytes for addresses 0x00..0x7F are acknowledged but discarded. If no byte of a write is kept, no write cycle starts and the slave acknowledges at once after STOP.
- R12: If SCL stays low for `TIMEOUT_CYCLES` clocks between START and STOP, the slave releases SDA and returns to idle, ready for a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device-select straps matched against address bits 3..1 |
| wp_lo_i | input | 1 | Lower-half write protect from the protection block |
| sda_pd_o | output | 1 | SDA pull-down enable (1 pulls the line low) |

## Verification
The bench tries single-byte writes, page writes that run past the page end, address-only writes, selective reads, reads that cross the top of the array, and immediate reads that continue from the pointer. Together these separate the in-page wrap used by writes from the full-array wrap used by reads. Address bytes with a wrong select code, a wrong strap and the right value tell the address match apart from the busy NACK that is used for polling. Protected and unprotected writes made with the protect input high show whether a discarded write still starts a cycle. An SCL low phase stretched past the limit while the slave holds an acknowledge shows the timeout recovery.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } xfer_st_t;

  localparam logic [3:0] MEM_SELECT = 4'b1010;
  localparam int         BYTE_W     = 8;
endpackage

// File: rtl/i2c_bus_sense.sv
// Synchronises SCL/SDA and flags edges, START and STOP.
module i2c_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_d  <= scl_sh[SYNC-1];
      sda_d  <= sda_sh[SYNC-1];
    end
  end

  assign scl_q     = scl_sh[SYNC-1];
  assign sda_q     = sda_sh[SYNC-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // data edge while the clock stays high
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/spd_mem_array.sv
// Byte array with one write port and a registered read port.
module spd_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spd_page_buf.sv
// Page buffer with per-entry keep flags and the timed commit sequencer.
module spd_page_buf #(
  parameter int OFS_W  = 4,
  parameter int DW     = 8,
  parameter int WR_CYC = 1_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [OFS_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic             ld_keep,
  input  logic             clr,
  input  logic             go,
  output logic             busy,
  output logic             mem_we,
  output logic [OFS_W-1:0] mem_idx,
  output logic [DW-1:0]    mem_data
);
  localparam int DEPTH = 1 << OFS_W;
  localparam int CW    = $clog2(WR_CYC + 1);

  logic [DW-1:0]    buf_q [DEPTH];
  logic [DEPTH-1:0] keep_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (ld && !busy_q) buf_q[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(WR_CYC - 1)) begin
        busy_q <= 1'b0;
        keep_q <= '0;
      end
    end else if (go && (|keep_q)) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (clr) begin
      keep_q <= '0;
    end else if (ld) begin
      keep_q[ld_idx] <= ld_keep;
    end
  end

  // one page entry per clock during the first DEPTH cycles
  assign busy     = busy_q;
  assign mem_idx  = cnt_q[OFS_W-1:0];
  assign mem_we   = busy_q && (cnt_q < CW'(DEPTH)) && keep_q[mem_idx];
  assign mem_data = buf_q[mem_idx];
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave
  import spd_pkg::*;
#(
  parameter int PAGE_W         = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int WR_CYCLES      = 1_000_000,
  parameter int TIMEOUT_CYCLES = 5_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_lo_i,
  output logic       sda_pd_o
);
  localparam int ADDR_W = BYTE_W;
  localparam int TW     = $clog2(TIMEOUT_CYCLES + 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sense #(.SYNC(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  xfer_st_t           st_q;
  logic [3:0]         bit_q;
  logic [BYTE_W-1:0]  sh_q, dout_q;
  logic               rw_q, mack_q, in_xfer_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [TW-1:0]      to_q;

  logic               pb_busy, mem_we, timeout_hit, dev_hit, pb_ld, pb_keep;
  logic [PAGE_W-1:0]  pb_idx;
  logic [BYTE_W-1:0]  pb_data, rdata;
  logic [2:0]         tx_idx;

  assign timeout_hit = in_xfer_q && !scl_q && (to_q == TW'(TIMEOUT_CYCLES - 1));
  assign dev_hit     = (sh_q[7:4] == MEM_SELECT) && (sh_q[3:1] == strap_i) && !pb_busy;
  assign pb_ld       = scl_fall && (bit_q == 4'd8) && (st_q == ST_WDATA);
  assign pb_keep     = !(wp_lo_i && !ptr_q[ADDR_W-1]);
  assign tx_idx      = 3'(4'd7 - bit_q);

  spd_page_buf #(.OFS_W(PAGE_W), .DW(BYTE_W), .WR_CYC(WR_CYCLES)) u_pbuf (
    .clk(clk), .rst(rst),
    .ld(pb_ld), .ld_idx(ptr_q[PAGE_W-1:0]), .ld_data(sh_q), .ld_keep(pb_keep),
    .clr(start_det || timeout_hit), .go(stop_det),
    .busy(pb_busy), .mem_we(mem_we), .mem_idx(pb_idx), .mem_data(pb_data)
  );

  // page base stays fixed while busy: no address is accepted then
  spd_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({ptr_q[ADDR_W-1:PAGE_W], pb_idx}),
    .wdata(pb_data), .raddr(ptr_q), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      dout_q    <= '1;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      in_xfer_q <= 1'b0;
      ptr_q     <= '0;
      sda_pd_o  <= 1'b0;
      to_q      <= '0;
    end else begin
      if (in_xfer_q && !scl_q) to_q <= to_q + TW'(1);
      else                     to_q <= '0;

      if (timeout_hit) begin
        st_q      <= ST_IDLE;
        in_xfer_q <= 1'b0;
        sda_pd_o  <= 1'b0;
        bit_q     <= '0;
        to_q      <= '0;
      end else if (start_det) begin
        st_q      <= ST_DEV;
        bit_q     <= '0;
        in_xfer_q <= 1'b1;
        sda_pd_o  <= 1'b0;
      end else if (stop_det) begin
        st_q      <= ST_IDLE;
        in_xfer_q <= 1'b0;
        sda_pd_o  <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_q};
            bit_q <= bit_q + 4'd1;
          end else if (bit_q == 4'd8) begin
            mack_q <= !sda_q;
            bit_q  <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bit_q == 4'd8) begin
            // acknowledge slot opens
            case (st_q)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_pd_o <= 1'b1;
                  rw_q     <= sh_q[0];
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                sda_pd_o <= 1'b1;
                ptr_q    <= sh_q;
              end
              ST_WDATA: begin
                sda_pd_o <= 1'b1;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
              end
              default: sda_pd_o <= 1'b0;
            endcase
          end else if (bit_q == 4'd9) begin
            // acknowledge slot closes
            bit_q <= '0;
            case (st_q)
              ST_DEV: begin
                if (rw_q) begin
                  st_q     <= ST_RDATA;
                  dout_q   <= rdata;
                  ptr_q    <= ptr_q + ADDR_W'(1);
                  sda_pd_o <= !rdata[7];
                end else begin
                  st_q     <= ST_WADDR;
                  sda_pd_o <= 1'b0;
                end
              end
              ST_WADDR: begin
                st_q     <= ST_WDATA;
                sda_pd_o <= 1'b0;
              end
              ST_RDATA: begin
                if (mack_q) begin
                  dout_q   <= rdata;
                  ptr_q    <= ptr_q + ADDR_W'(1);
                  sda_pd_o <= !rdata[7];
                end else begin
                  st_q     <= ST_IDLE;
                  sda_pd_o <= 1'b0;
                end
              end
              default: sda_pd_o <= 1'b0;
            endcase
          end else if (st_q == ST_RDATA && bit_q != 4'd0) begin
            sda_pd_o <= !dout_q[tx_idx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_slave_chk.sv
module spd_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic busy,
  input logic stop_det,
  input logic timeout_hit,
  input logic sda_pd
);
  // R10: pull-down only begins while the synchronised clock is low
  p_drive_on_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pd) |-> !scl_s);

  // R6: silent on the bus during a write cycle
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pd);

  // R5: a write cycle begins only on a STOP
  p_cycle_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R12: timeout releases the data line
  p_timeout_release_r12: assert property (@(posedge clk) disable iff (rst)
    timeout_hit |=> !sda_pd);
endmodule

bind spd_eeprom_slave spd_eeprom_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_q), .busy(pb_busy),
  .stop_det(stop_det), .timeout_hit(timeout_hit), .sda_pd(sda_pd_o)
);

// File: tb/spd_eeprom_slave_test.sv
`timescale 1ns/1ps
module spd_eeprom_slave_test;
  localparam int WR  = 300;
  localparam int TO  = 400;
  localparam int Q   = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_pd;
  wire  sda_line = sda_m & ~sda_pd;

  always #2.5 clk = ~clk;

  spd_eeprom_slave #(.WR_CYCLES(WR), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .wp_lo_i(wp), .sda_pd_o(sda_pd)
  );

  int n_chk = 0, n_err = 0, hi_viol = 0;
  bit done = 0;
  logic [7:0] model_mem [256];
  int model_ptr = 0;
  logic [7:0] wq[$];
  logic scl_prev = 1'b1, pd_prev = 1'b0;

  // R10 monitor: pull-down must not move while SCL stays high
  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && (sda_pd !== pd_prev)) hi_viol++;
    scl_prev = scl_m;
    pd_prev  = sda_pd;
  end

  task automatic tick(int n); repeat (n) @(posedge clk); endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic bus_start();
    tick(Q/2); sda_m = 1; tick(Q/2); scl_m = 1; tick(Q/2); sda_m = 0; tick(Q/2); scl_m = 0;
  endtask
  task automatic bus_stop();
    tick(Q/2); sda_m = 0; tick(Q/2); scl_m = 1; tick(Q/2); sda_m = 1; tick(Q);
  endtask
  task automatic send8(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q/2); sda_m = b[i]; tick(Q/2); scl_m = 1; tick(Q); scl_m = 0;
    end
  endtask
  task automatic ack_slot(output logic a);
    tick(Q/2); sda_m = 1; tick(Q/2); scl_m = 1; tick(Q/2); #1 a = sda_pd; tick(Q/2); scl_m = 0;
  endtask
  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q/2); #1 b[i] = ~sda_pd; tick(Q/2); scl_m = 0;
    end
    tick(Q/2); sda_m = !give_ack; tick(Q/2); scl_m = 1; tick(Q); scl_m = 0;
  endtask
  task automatic poll(input logic [7:0] b, output logic a);
    bus_start(); send8(b); ack_slot(a); bus_stop();
  endtask

  task automatic write_seq(input logic [7:0] addr, input string req);
    logic a; logic [7:0] kbuf [16]; bit keep [16]; int idx;
    bus_start();
    send8(DEV_W); ack_slot(a); check(a === 1'b1, req, "device ack", a, 1);
    send8(addr);  ack_slot(a); check(a === 1'b1, req, "address ack", a, 1);
    idx = addr[3:0];
    foreach (wq[k]) begin
      send8(wq[k]); ack_slot(a); check(a === 1'b1, req, "data ack", a, 1);
      kbuf[idx] = wq[k];
      keep[idx] = !(wp && addr < 8'h80);
      idx = (idx + 1) % 16;
    end
    bus_stop();
    for (int j = 0; j < 16; j++) if (keep[j]) model_mem[{addr[7:4], 4'(j)}] = kbuf[j];
    model_ptr = {addr[7:4], 4'(idx)};
    wq.delete();
  endtask

  task automatic read_seq(input bit sel, input logic [7:0] addr, input int n, input string req);
    logic a; logic [7:0] d;
    if (sel) begin
      bus_start();
      send8(DEV_W); ack_slot(a); check(a === 1'b1, req, "select device ack", a, 1);
      send8(addr);  ack_slot(a); check(a === 1'b1, req, "select address ack", a, 1);
      model_ptr = addr;
    end
    bus_start();
    send8(DEV_R); ack_slot(a); check(a === 1'b1, req, "read device ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      check(d === model_mem[model_ptr], req, $sformatf("read data @%0h", model_ptr), d, model_mem[model_ptr]);
      model_ptr = (model_ptr + 1) % 256;
    end
    check(sda_pd === 1'b0, "R9", "released after master NACK", sda_pd, 0);
    bus_stop();
    check(sda_pd === 1'b0, "R9", "released after STOP", sda_pd, 0);
  endtask

  initial begin
    tick(150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic a;
    for (int i = 0; i < 256; i++) model_mem[i] = 8'hFF;
    tick(10); rst = 0; tick(5);
    // R1 reset state
    check(sda_pd === 1'b0, "R1", "SDA released after reset", sda_pd, 0);
    read_seq(0, 8'h00, 1, "R1");

    // R2 address match
    poll({4'b1011, STRAP, 1'b0}, a); check(a === 1'b0, "R2", "wrong select code nack", a, 0);
    poll({4'b1010, 3'b001, 1'b0}, a); check(a === 1'b0, "R2", "wrong strap nack", a, 0);
    poll(DEV_W, a); check(a === 1'b1, "R2", "matching address ack", a, 1);

    // R3 byte write, R6 busy polling, R8 selective read
    wq.push_back(8'h3C); write_seq(8'h85, "R3");
    poll(DEV_W, a); check(a === 1'b0, "R6", "nack during write cycle", a, 0);
    tick(WR);
    poll(DEV_W, a); check(a === 1'b1, "R6", "ack after write cycle", a, 1);
    read_seq(1, 8'h85, 1, "R8");

    // R4 page write past page end
    for (int k = 0; k < 18; k++) wq.push_back(8'h40 + 8'(k));
    write_seq(8'h9E, "R4");
    tick(WR + 20);
    read_seq(1, 8'h90, 17, "R4");

    // R7 read wrap across top of array, immediate continue
    wq.push_back(8'h11); wq.push_back(8'h22); write_seq(8'h00, "R3");
    tick(WR + 20);
    read_seq(1, 8'hFE, 4, "R7");
    read_seq(0, 8'h00, 1, "R7");

    // R5 address-only write starts no cycle
    bus_start(); send8(DEV_W); ack_slot(a); send8(8'h40); ack_slot(a); bus_stop();
    poll(DEV_W, a); check(a === 1'b1, "R5", "no cycle after address-only write", a, 1);

    // R11 lower-half protection
    wp = 1;
    wq.push_back(8'h77); write_seq(8'h10, "R11");
    poll(DEV_W, a); check(a === 1'b1, "R11", "no cycle when all bytes discarded", a, 1);
    read_seq(1, 8'h10, 1, "R11");
    wq.push_back(8'h5A); write_seq(8'h90, "R11");
    poll(DEV_W, a); check(a === 1'b0, "R11", "upper half still committed", a, 0);
    tick(WR);
    read_seq(1, 8'h90, 1, "R11");
    wp = 0;

    // R12 clock-low timeout while acknowledge is held
    bus_start(); send8(DEV_W);
    tick(10);
    check(sda_pd === 1'b1, "R12", "ack held before timeout", sda_pd, 1);
    tick(TO + 20);
    check(sda_pd === 1'b0, "R12", "released after timeout", sda_pd, 0);
    read_seq(1, 8'h85, 1, "R12");

    check(hi_viol == 0, "R10", "SDA changes while SCL high", hi_viol, 0);
    summary();
  end
endmodule